// File: doc/BRIEF.md
# Address translation controller

This block steers each memory access through address translation and reports how it ended. An access is presented as a virtual address with three flags: fetch or data, write or read, and a quiet flag that asks for no side effects on failure. With the access come the machine-state bits (relocation enables for fetches and for data, and user mode) and the attributes of the segment the address falls in (no-execute, user key, supervisor key). If relocation is off for the kind of access, the address passes straight through as read-write. Otherwise the controller asks an external block-range matcher first. If no range matches, it asks an external page-table walker and applies page protection to the entry that comes back.

A failed access either stays silent (quiet flag) or loads fault registers and raises one exception vector. A core-variant select picks between two fault styles. The software-reload style records the address in a fetch-miss or data-miss register, sets a sticky temporary-register-set flag, and picks the vector from the kind of access. The architected style records the address and a status word for data faults only, separating "no entry found" from "protection", and raises a data-storage or instruction-storage vector.

The sequencer has four states. IDLE accepts a request: it goes to BLOCK when relocation is on, and otherwise stays in IDLE and completes at once. BLOCK waits for the matcher: a hit that grants access returns to IDLE (complete), a hit that denies access goes to FAULT, and a miss goes to WALK. WALK waits for the walker: a granted entry returns to IDLE (complete), and a missing or denied entry goes to FAULT. FAULT lasts one cycle, completes with the failure code and returns to IDLE.

Top module: `xlate_ctrl`

## Requirements
- R1: When relocation is off for the access kind (ms_ir for fetches, ms_dr for data), the access completes with phys_addr equal to req_addr and res_code 2 (read-write). Neither the matcher nor the walker is asked.
- R2: A block-range hit with perm 1 (read-only) or perm 2/3 (read-write) completes with the matcher's physical address and no walk. A write to a read-only range fails.
- R3: A block-range hit with perm 0 fails as a protection fault: status gets the protection bit in the architected style, and the vector follows the access kind in the software-reload style.
- R4: The protection key is seg_key_user in user mode (ms_user=1) and seg_key_sup in supervisor mode.
- R5: Page protection pp[1:0]: with the key set, 0 is denied, 1 and 3 are read-only and 2 is read-write; with the key clear, 3 is read-only and 0, 1 and 2 are read-write. A write to a read-only page fails.
- R6: On a page success, phys_addr is the walker's real page number (upper AW-12 bits) joined with req_addr[11:0].
- R7: A fetch that finds a page fails as a protection fault if seg_noexec is set or the entry's guard bit is set. Data accesses ignore the guard bit.
- R8: Architected style (sw_reload=0): a failed data access sets fault_addr to the address, and sets fault_status to 0x0800_0000 (protection, an entry or range matched) or 0x4000_0000 (not found), OR 0x0200_0000 on writes. Vector is 0x03 for data and 0x04 for fetch. A failed fetch leaves fault_addr and fault_status unchanged.
- R9: Software-reload style (sw_reload=1): a failure stores the address in miss_iaddr (fetch) or miss_daddr (data), sets tgpr (sticky until reset), and raises vector 0x10 for a fetch, 0x11 for a load or 0x12 for a store. fault_addr and fault_status are not touched.
- R10: With req_quiet set, a failure completes with res_code 0 and changes no fault register, miss register, tgpr or exc_valid.
- R11: done is a one-cycle pulse per accepted request, with res_code 0 = fail, 1 = read-only, 2 = read-write. Latency from the accepting edge is 1 cycle for pass-through, 2 for a block grant, 3 for a block denial or page grant, and 4 for a page failure. A request raised while busy is ignored.
- R12: After reset, done, exc_valid, tgpr, blk_req, walk_req, res_code and all fault and miss registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, accepted in IDLE |
| req_addr | input | AW | Virtual address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_write | input | 1 | 1 = store |
| req_quiet | input | 1 | Suppress fault side effects |
| ms_ir | input | 1 | Fetch relocation enable |
| ms_dr | input | 1 | Data relocation enable |
| ms_user | input | 1 | User (problem) mode |
| seg_noexec | input | 1 | Segment forbids execution |
| seg_key_user | input | 1 | Segment key used in user mode |
| seg_key_sup | input | 1 | Segment key used in supervisor mode |
| sw_reload | input | 1 | 1 = software-reload fault style |
| blk_req | output | 1 | Matcher request, held until response |
| blk_addr | output | AW | Address for the matcher |
| blk_fetch | output | 1 | Access kind for the matcher |
| blk_user | output | 1 | Mode for the matcher |
| blk_rsp_valid | input | 1 | Matcher response valid |
| blk_rsp_hit | input | 1 | A range matched |
| blk_rsp_perm | input | 2 | 0 denied, 1 read-only, 2/3 read-write |
| blk_rsp_phys | input | AW | Matcher physical address |
| walk_req | output | 1 | Walker request, held until response |
| walk_addr | output | AW | Address for the walker |
| walk_fetch | output | 1 | Access kind for the walker |
| walk_rsp_valid | input | 1 | Walker response valid |
| walk_rsp_found | input | 1 | An entry was found |
| walk_rsp_rpn | input | AW-12 | Real page number |
| walk_rsp_guard | input | 1 | Entry guard bit |
| walk_rsp_pp | input | 2 | Entry page protection |
| done | output | 1 | Completion pulse |
| res_code | output | 2 | Result code |
| phys_addr | output | AW | Physical address on success, 0 on failure |
| exc_valid | output | 1 | Exception pulse, with done |
| exc_vector | output | 8 | Exception vector |
| miss_iaddr | output | AW | Fetch-miss address register |
| miss_daddr | output | AW | Data-miss address register |
| tgpr | output | 1 | Temporary-register-set flag |
| fault_addr | output | AW | Data fault address register |
| fault_status | output | 32 | Data fault status word |

## Verification
A pass-through result is due one cycle after the accepting edge, a block grant two, a block denial or page grant three, and a page failure four. Fault registers, miss registers, tgpr and the exception pulse change on the same edge as done. The bench drives a request on a falling edge and polls done on each later falling edge, counting edges. It checks the measured latency against the expected one and reads every result and register at that same sample. The matcher and walker models answer in the cycle they are asked, so these counts are exact. A hold on the walker stretches one access to prove that a request raised while busy is ignored.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BLOCK,
        S_WALK,
        S_FAULT
    } xl_state_e;

    localparam int VW  = 8;
    localparam int STW = 32;

    localparam logic [1:0] RES_FAIL = 2'd0;
    localparam logic [1:0] RES_RO   = 2'd1;
    localparam logic [1:0] RES_RW   = 2'd2;

    localparam logic [VW-1:0] VEC_DSI      = 8'h03;
    localparam logic [VW-1:0] VEC_ISI      = 8'h04;
    localparam logic [VW-1:0] VEC_SW_FETCH = 8'h10;
    localparam logic [VW-1:0] VEC_SW_LOAD  = 8'h11;
    localparam logic [VW-1:0] VEC_SW_STORE = 8'h12;

    localparam logic [STW-1:0] ST_NOTFOUND = 32'h4000_0000;
    localparam logic [STW-1:0] ST_PROT     = 32'h0800_0000;
    localparam logic [STW-1:0] ST_STORE    = 32'h0200_0000;

    // a read-only grant turns into a failure for a store
    function automatic logic [1:0] limit_write(input logic [1:0] g, input logic wr);
        return (wr && g == RES_RO) ? RES_FAIL : g;
    endfunction

    // block-range permission to grant code
    function automatic logic [1:0] range_grant(input logic [1:0] perm);
        unique case (perm)
            2'd0:    return RES_FAIL;
            2'd1:    return RES_RO;
            default: return RES_RW;
        endcase
    endfunction

endpackage

// File: rtl/xlate_prot.sv
module xlate_prot
    import xlate_pkg::*;
(
    input  logic       fetch,
    input  logic       write,
    input  logic       user,
    input  logic       noexec,
    input  logic       key_user,
    input  logic       key_sup,
    input  logic       guard,
    input  logic [1:0] pp,
    output logic [1:0] grant
);

    logic       key;
    logic [1:0] raw;

    always_comb begin
        key = user ? key_user : key_sup;
        if (key) begin
            unique case (pp)
                2'd0:    raw = RES_FAIL;
                2'd2:    raw = RES_RW;
                default: raw = RES_RO;
            endcase
        end else begin
            raw = (pp == 2'd3) ? RES_RO : RES_RW;
        end
        if (fetch && (noexec || guard)) begin
            grant = RES_FAIL;
        end else begin
            grant = limit_write(raw, write);
        end
    end

endmodule

// File: rtl/xlate_fault.sv
module xlate_fault
    import xlate_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire,
    input  logic           sw_style,
    input  logic           fetch,
    input  logic           write,
    input  logic           matched,
    input  logic [AW-1:0]  addr,
    output logic           exc_valid,
    output logic [VW-1:0]  exc_vector,
    output logic [AW-1:0]  miss_iaddr,
    output logic [AW-1:0]  miss_daddr,
    output logic           tgpr,
    output logic [AW-1:0]  fault_addr,
    output logic [STW-1:0] fault_status
);

    logic [STW-1:0] cause;

    always_comb begin
        cause = matched ? ST_PROT : ST_NOTFOUND;
        if (write) begin
            cause = cause | ST_STORE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_valid    <= 1'b0;
            exc_vector   <= '0;
            miss_iaddr   <= '0;
            miss_daddr   <= '0;
            tgpr         <= 1'b0;
            fault_addr   <= '0;
            fault_status <= '0;
        end else begin
            exc_valid <= 1'b0;
            if (fire) begin
                exc_valid <= 1'b1;
                if (sw_style) begin
                    tgpr <= 1'b1;
                    if (fetch) begin
                        miss_iaddr <= addr;
                        exc_vector <= VEC_SW_FETCH;
                    end else begin
                        miss_daddr <= addr;
                        exc_vector <= write ? VEC_SW_STORE : VEC_SW_LOAD;
                    end
                end else begin
                    if (fetch) begin
                        exc_vector <= VEC_ISI;
                    end else begin
                        exc_vector   <= VEC_DSI;
                        fault_addr   <= addr;
                        fault_status <= cause;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import xlate_pkg::*;
#(
    parameter int AW     = 32,
    parameter int PG_OFF = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_addr,
    input  logic                 req_fetch,
    input  logic                 req_write,
    input  logic                 req_quiet,
    input  logic                 ms_ir,
    input  logic                 ms_dr,
    input  logic                 ms_user,
    input  logic                 seg_noexec,
    input  logic                 seg_key_user,
    input  logic                 seg_key_sup,
    input  logic                 sw_reload,
    output logic                 blk_req,
    output logic [AW-1:0]        blk_addr,
    output logic                 blk_fetch,
    output logic                 blk_user,
    input  logic                 blk_rsp_valid,
    input  logic                 blk_rsp_hit,
    input  logic [1:0]           blk_rsp_perm,
    input  logic [AW-1:0]        blk_rsp_phys,
    output logic                 walk_req,
    output logic [AW-1:0]        walk_addr,
    output logic                 walk_fetch,
    input  logic                 walk_rsp_valid,
    input  logic                 walk_rsp_found,
    input  logic [AW-PG_OFF-1:0] walk_rsp_rpn,
    input  logic                 walk_rsp_guard,
    input  logic [1:0]           walk_rsp_pp,
    output logic                 done,
    output logic [1:0]           res_code,
    output logic [AW-1:0]        phys_addr,
    output logic                 exc_valid,
    output logic [VW-1:0]        exc_vector,
    output logic [AW-1:0]        miss_iaddr,
    output logic [AW-1:0]        miss_daddr,
    output logic                 tgpr,
    output logic [AW-1:0]        fault_addr,
    output logic [STW-1:0]       fault_status
);

    localparam int RPN_W = AW - PG_OFF;

    xl_state_e state, nxt;

    logic [AW-1:0] q_addr;
    logic          q_fetch, q_write, q_quiet, q_user;
    logic          q_noexec, q_kuser, q_ksup, q_sw, q_matched;

    logic          accept;
    logic          reloc_now;
    logic [1:0]    blk_grant;
    logic [1:0]    page_grant;
    logic          fault_fire;

    assign accept     = (state == S_IDLE) && req_valid;
    assign reloc_now  = req_fetch ? ms_ir : ms_dr;
    assign blk_grant  = limit_write(range_grant(blk_rsp_perm), q_write);
    assign fault_fire = (state == S_FAULT) && !q_quiet;

    assign blk_req    = (state == S_BLOCK);
    assign blk_addr   = q_addr;
    assign blk_fetch  = q_fetch;
    assign blk_user   = q_user;
    assign walk_req   = (state == S_WALK);
    assign walk_addr  = q_addr;
    assign walk_fetch = q_fetch;

    xlate_prot u_prot (
        .fetch    (q_fetch),
        .write    (q_write),
        .user     (q_user),
        .noexec   (q_noexec),
        .key_user (q_kuser),
        .key_sup  (q_ksup),
        .guard    (walk_rsp_guard),
        .pp       (walk_rsp_pp),
        .grant    (page_grant)
    );

    xlate_fault #(.AW(AW)) u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fault_fire),
        .sw_style     (q_sw),
        .fetch        (q_fetch),
        .write        (q_write),
        .matched      (q_matched),
        .addr         (q_addr),
        .exc_valid    (exc_valid),
        .exc_vector   (exc_vector),
        .miss_iaddr   (miss_iaddr),
        .miss_daddr   (miss_daddr),
        .tgpr         (tgpr),
        .fault_addr   (fault_addr),
        .fault_status (fault_status)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid && reloc_now) begin
                    nxt = S_BLOCK;
                end
            end
            S_BLOCK: begin
                if (blk_rsp_valid) begin
                    if (!blk_rsp_hit) begin
                        nxt = S_WALK;
                    end else if (blk_grant == RES_FAIL) begin
                        nxt = S_FAULT;
                    end else begin
                        nxt = S_IDLE;
                    end
                end
            end
            S_WALK: begin
                if (walk_rsp_valid) begin
                    if (walk_rsp_found && page_grant != RES_FAIL) begin
                        nxt = S_IDLE;
                    end else begin
                        nxt = S_FAULT;
                    end
                end
            end
            S_FAULT: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // outputs and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            res_code  <= RES_FAIL;
            phys_addr <= '0;
            q_addr    <= '0;
            q_fetch   <= 1'b0;
            q_write   <= 1'b0;
            q_quiet   <= 1'b0;
            q_user    <= 1'b0;
            q_noexec  <= 1'b0;
            q_kuser   <= 1'b0;
            q_ksup    <= 1'b0;
            q_sw      <= 1'b0;
            q_matched <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        q_addr    <= req_addr;
                        q_fetch   <= req_fetch;
                        q_write   <= req_write;
                        q_quiet   <= req_quiet;
                        q_user    <= ms_user;
                        q_noexec  <= seg_noexec;
                        q_kuser   <= seg_key_user;
                        q_ksup    <= seg_key_sup;
                        q_sw      <= sw_reload;
                        q_matched <= 1'b0;
                        if (!reloc_now) begin
                            done      <= 1'b1;
                            res_code  <= RES_RW;
                            phys_addr <= req_addr;
                        end
                    end
                end
                S_BLOCK: begin
                    if (blk_rsp_valid && blk_rsp_hit) begin
                        q_matched <= 1'b1;
                        if (blk_grant != RES_FAIL) begin
                            done      <= 1'b1;
                            res_code  <= blk_grant;
                            phys_addr <= blk_rsp_phys;
                        end
                    end
                end
                S_WALK: begin
                    if (walk_rsp_valid) begin
                        q_matched <= walk_rsp_found;
                        if (walk_rsp_found && page_grant != RES_FAIL) begin
                            done      <= 1'b1;
                            res_code  <= page_grant;
                            phys_addr <= {walk_rsp_rpn[RPN_W-1:0], q_addr[PG_OFF-1:0]};
                        end
                    end
                end
                S_FAULT: begin
                    done      <= 1'b1;
                    res_code  <= RES_FAIL;
                    phys_addr <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/xlate_ctrl_chk.sv
module xlate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       accept,
    input logic       req_quiet,
    input logic       req_fetch,
    input logic       req_write,
    input logic       sw_reload,
    input logic       blk_req,
    input logic       walk_req,
    input logic       done,
    input logic [1:0] res_code,
    input logic       exc_valid,
    input logic [7:0] exc_vector,
    input logic       tgpr
);

    logic c_quiet, c_fetch, c_write, c_sw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_quiet <= 1'b0;
            c_fetch <= 1'b0;
            c_write <= 1'b0;
            c_sw    <= 1'b0;
        end else if (accept) begin
            c_quiet <= req_quiet;
            c_fetch <= req_fetch;
            c_write <= req_write;
            c_sw    <= sw_reload;
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_code != 2'd3);

    // R11
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_req && walk_req));

    // R8
    exc_with_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (done && res_code == 2'd0));

    // R10
    quiet_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_quiet) |-> !exc_valid);

    // R9
    tgpr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgpr |=> tgpr);

    // R9
    sw_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && c_sw) |->
            exc_vector == (c_fetch ? 8'h10 : (c_write ? 8'h12 : 8'h11)));

    // R8
    arch_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !c_sw) |-> exc_vector == (c_fetch ? 8'h04 : 8'h03));

endmodule

bind xlate_ctrl xlate_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_quiet  (req_quiet),
    .req_fetch  (req_fetch),
    .req_write  (req_write),
    .sw_reload  (sw_reload),
    .blk_req    (blk_req),
    .walk_req   (walk_req),
    .done       (done),
    .res_code   (res_code),
    .exc_valid  (exc_valid),
    .exc_vector (exc_vector),
    .tgpr       (tgpr)
);

// File: tb/sim_xlate_ctrl.sv
module sim_xlate_ctrl;

    typedef struct packed {
        logic [31:0] addr;
        logic        fetch;
        logic        write;
        logic        quiet;
        logic        ir;
        logic        dr;
        logic        user;
        logic        noexec;
        logic        kuser;
        logic        ksup;
        logic        sw;
        logic        bhit;
        logic [1:0]  bperm;
        logic [31:0] bphys;
        logic        wfound;
        logic [19:0] wrpn;
        logic        wguard;
        logic [1:0]  wpp;
        logic [1:0]  e_code;
        logic [31:0] e_phys;
        logic        e_exc;
        logic [7:0]  e_vec;
        logic [3:0]  e_lat;
        logic [31:0] e_faddr;
        logic [31:0] e_fstat;
        logic        e_tgpr;
    } vec_t;

    localparam int NV = 19;
    // addr fetch write quiet ir dr user nx ku ks sw | bhit bperm bphys | wfound rpn guard pp |
    // code phys exc vec lat | faddr fstat tgpr
    localparam vec_t VEC [NV] = '{
        '{32'h1234_5678,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b0,20'h0,1'b0,2'd0,
          2'd2,32'h1234_5678,1'b0,8'h00,4'd1, 32'h0,32'h0,1'b0},
        '{32'hDEAD_B000,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b0,20'h0,1'b0,2'd0,
          2'd2,32'hDEAD_B000,1'b0,8'h00,4'd1, 32'h0,32'h0,1'b0},
        '{32'h0F00_0123,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd2,32'h0040_0123, 1'b0,20'h0,1'b0,2'd0,
          2'd2,32'h0040_0123,1'b0,8'h00,4'd2, 32'h0,32'h0,1'b0},
        '{32'h0050_0000,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,32'h0050_0000, 1'b0,20'h0,1'b0,2'd0,
          2'd0,32'h0,1'b1,8'h03,4'd3, 32'h0050_0000,32'h0A00_0000,1'b0},
        '{32'h1000_0456,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'hABCDE,1'b0,2'd0,
          2'd2,32'hABCD_E456,1'b0,8'h00,4'd3, 32'h0050_0000,32'h0A00_0000,1'b0},
        '{32'h2000_0010,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'h77777,1'b0,2'd0,
          2'd0,32'h0,1'b1,8'h03,4'd4, 32'h2000_0010,32'h0800_0000,1'b0},
        '{32'h3000_0ABC,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'h11111,1'b0,2'd1,
          2'd1,32'h1111_1ABC,1'b0,8'h00,4'd3, 32'h2000_0010,32'h0800_0000,1'b0},
        '{32'h6000_0020,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'h22222,1'b0,2'd3,
          2'd0,32'h0,1'b1,8'h03,4'd4, 32'h6000_0020,32'h0A00_0000,1'b0},
        '{32'h4000_0FFF,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'h33333,1'b0,2'd1,
          2'd2,32'h3333_3FFF,1'b0,8'h00,4'd3, 32'h6000_0020,32'h0A00_0000,1'b0},
        '{32'h5000_0001,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'h44444,1'b0,2'd3,
          2'd1,32'h4444_4001,1'b0,8'h00,4'd3, 32'h6000_0020,32'h0A00_0000,1'b0},
        '{32'h7000_0030,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b0,20'h0,1'b0,2'd0,
          2'd0,32'h0,1'b1,8'h03,4'd4, 32'h7000_0030,32'h4000_0000,1'b0},
        '{32'h0C00_0100,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'h55555,1'b1,2'd2,
          2'd0,32'h0,1'b1,8'h04,4'd4, 32'h7000_0030,32'h4000_0000,1'b0},
        '{32'h0C00_0200,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'h66666,1'b0,2'd2,
          2'd0,32'h0,1'b1,8'h04,4'd4, 32'h7000_0030,32'h4000_0000,1'b0},
        '{32'h8000_0040,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,2'd0,32'h0, 1'b0,20'h0,1'b0,2'd0,
          2'd0,32'h0,1'b1,8'h12,4'd4, 32'h7000_0030,32'h4000_0000,1'b1},
        '{32'h8000_0050,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,2'd0,32'h0, 1'b0,20'h0,1'b0,2'd0,
          2'd0,32'h0,1'b1,8'h11,4'd4, 32'h7000_0030,32'h4000_0000,1'b1},
        '{32'h9000_0060,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,2'd0,32'h0, 1'b0,20'h0,1'b0,2'd0,
          2'd0,32'h0,1'b1,8'h10,4'd4, 32'h7000_0030,32'h4000_0000,1'b1},
        '{32'hB000_0080,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,2'd0,32'h1234_0000, 1'b0,20'h0,1'b0,2'd0,
          2'd0,32'h0,1'b1,8'h11,4'd3, 32'h7000_0030,32'h4000_0000,1'b1},
        '{32'hA000_0070,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b0,20'h0,1'b0,2'd0,
          2'd0,32'h0,1'b0,8'h00,4'd4, 32'h7000_0030,32'h4000_0000,1'b1},
        '{32'h0D00_0345,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,32'h0, 1'b1,20'h55555,1'b1,2'd2,
          2'd2,32'h5555_5345,1'b0,8'h00,4'd3, 32'h7000_0030,32'h4000_0000,1'b1}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_fetch, req_write, req_quiet;
    logic        ms_ir, ms_dr, ms_user;
    logic        seg_noexec, seg_key_user, seg_key_sup, sw_reload;
    logic        blk_req, blk_fetch, blk_user;
    logic [31:0] blk_addr;
    logic        blk_rsp_valid, blk_rsp_hit;
    logic [1:0]  blk_rsp_perm;
    logic [31:0] blk_rsp_phys;
    logic        walk_req, walk_fetch;
    logic [31:0] walk_addr;
    logic        walk_rsp_valid, walk_rsp_found, walk_rsp_guard;
    logic [19:0] walk_rsp_rpn;
    logic [1:0]  walk_rsp_pp;
    logic        done;
    logic [1:0]  res_code;
    logic [31:0] phys_addr;
    logic        exc_valid;
    logic [7:0]  exc_vector;
    logic [31:0] miss_iaddr, miss_daddr, fault_addr, fault_status;
    logic        tgpr;

    vec_t cur;
    logic walk_hold;

    // matcher and walker models answer in the cycle they are asked
    assign blk_rsp_valid  = blk_req;
    assign blk_rsp_hit    = cur.bhit;
    assign blk_rsp_perm   = cur.bperm;
    assign blk_rsp_phys   = cur.bphys;
    assign walk_rsp_valid = walk_req && !walk_hold;
    assign walk_rsp_found = cur.wfound;
    assign walk_rsp_rpn   = cur.wrpn;
    assign walk_rsp_guard = cur.wguard;
    assign walk_rsp_pp    = cur.wpp;

    xlate_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
        .req_write(req_write), .req_quiet(req_quiet),
        .ms_ir(ms_ir), .ms_dr(ms_dr), .ms_user(ms_user),
        .seg_noexec(seg_noexec), .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup),
        .sw_reload(sw_reload),
        .blk_req(blk_req), .blk_addr(blk_addr), .blk_fetch(blk_fetch), .blk_user(blk_user),
        .blk_rsp_valid(blk_rsp_valid), .blk_rsp_hit(blk_rsp_hit),
        .blk_rsp_perm(blk_rsp_perm), .blk_rsp_phys(blk_rsp_phys),
        .walk_req(walk_req), .walk_addr(walk_addr), .walk_fetch(walk_fetch),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_found(walk_rsp_found),
        .walk_rsp_rpn(walk_rsp_rpn), .walk_rsp_guard(walk_rsp_guard), .walk_rsp_pp(walk_rsp_pp),
        .done(done), .res_code(res_code), .phys_addr(phys_addr),
        .exc_valid(exc_valid), .exc_vector(exc_vector),
        .miss_iaddr(miss_iaddr), .miss_daddr(miss_daddr), .tgpr(tgpr),
        .fault_addr(fault_addr), .fault_status(fault_status)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0, 1:        return "R1";
            2, 3:        return "R2";
            4:           return "R6";
            5, 7, 9:     return "R5";
            6, 8:        return "R4";
            10:          return "R8";
            11, 12, 18:  return "R7";
            13, 14, 15:  return "R9";
            16:          return "R3";
            default:     return "R10";
        endcase
    endfunction

    task automatic drive(input vec_t v);
        cur          = v;
        req_addr     = v.addr;
        req_fetch    = v.fetch;
        req_write    = v.write;
        req_quiet    = v.quiet;
        ms_ir        = v.ir;
        ms_dr        = v.dr;
        ms_user      = v.user;
        seg_noexec   = v.noexec;
        seg_key_user = v.kuser;
        seg_key_sup  = v.ksup;
        sw_reload    = v.sw;
    endtask

    task automatic run_row(input int i);
        vec_t  v;
        int    lat;
        string t;
        v = VEC[i];
        t = row_tag(i);
        @(negedge clk);
        drive(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == int'(v.e_lat), "R11", $sformatf("row %0d latency", i), lat, 32'(v.e_lat));
        chk(res_code == v.e_code, t, $sformatf("row %0d res_code", i), 32'(res_code), 32'(v.e_code));
        if (v.e_code != 2'd0) begin
            chk(phys_addr == v.e_phys, t, $sformatf("row %0d phys_addr", i), phys_addr, v.e_phys);
        end
        chk(exc_valid == v.e_exc, t, $sformatf("row %0d exc_valid", i), 32'(exc_valid), 32'(v.e_exc));
        if (v.e_exc) begin
            chk(exc_vector == v.e_vec, t, $sformatf("row %0d exc_vector", i), 32'(exc_vector), 32'(v.e_vec));
        end
        chk(fault_addr == v.e_faddr, "R8", $sformatf("row %0d fault_addr", i), fault_addr, v.e_faddr);
        chk(fault_status == v.e_fstat, "R8", $sformatf("row %0d fault_status", i), fault_status, v.e_fstat);
        chk(tgpr == v.e_tgpr, "R9", $sformatf("row %0d tgpr", i), 32'(tgpr), 32'(v.e_tgpr));
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        walk_hold = 1'b0;
        drive(VEC[0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(done == 1'b0, "R12", "done", 32'(done), 0);
        chk(exc_valid == 1'b0, "R12", "exc_valid", 32'(exc_valid), 0);
        chk(tgpr == 1'b0, "R12", "tgpr", 32'(tgpr), 0);
        chk(res_code == 2'd0, "R12", "res_code", 32'(res_code), 0);
        chk(!blk_req && !walk_req, "R12", "port requests", 32'({blk_req, walk_req}), 0);
        chk(fault_status == 32'h0 && fault_addr == 32'h0, "R12", "fault regs", fault_status | fault_addr, 0);
        chk(miss_iaddr == 32'h0 && miss_daddr == 32'h0, "R12", "miss regs", miss_iaddr | miss_daddr, 0);

        for (int i = 0; i < NV; i++) begin
            run_row(i);
        end

        // R9 miss registers hold the last failing address of each kind
        chk(miss_daddr == 32'hB000_0080, "R9", "miss_daddr", miss_daddr, 32'hB000_0080);
        chk(miss_iaddr == 32'h9000_0060, "R9", "miss_iaddr", miss_iaddr, 32'h9000_0060);

        // R11 a request raised while busy is ignored
        begin
            int pulses;
            walk_hold = 1'b1;
            @(negedge clk);
            drive(VEC[4]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            pulses = 0;
            repeat (2) begin
                @(negedge clk);
                if (done) pulses++;
            end
            req_addr  = 32'hFFFF_F000;
            ms_dr     = 1'b0;
            req_valid = 1'b1;
            @(negedge clk);
            if (done) pulses++;
            req_valid = 1'b0;
            @(negedge clk);
            if (done) pulses++;
            chk(pulses == 0, "R11", "done while walker held", 32'(pulses), 0);
            walk_hold = 1'b0;
            @(negedge clk);
            chk(done == 1'b1, "R11", "done after release", 32'(done), 1);
            chk(phys_addr == 32'hABCD_E456, "R11", "busy request ignored phys", phys_addr, 32'hABCD_E456);
            pulses = 0;
            repeat (5) begin
                @(negedge clk);
                if (done) pulses++;
            end
            chk(pulses == 0, "R11", "single done pulse", 32'(pulses), 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule